// File: doc/BRIEF.md
# Circular Byte Log Write Manager

This block sits between a data producer and a serial non-volatile memory that holds 128 KiB. It turns a stream of logged bytes into single-byte write requests. The last 256-byte page of the memory is kept apart. It holds a small persistent record with three fields: the session's read start, the next write position and the number of bytes logged. Each logging session therefore continues where the previous one stopped. Over time the writes spread across the whole data area instead of always hitting the lowest addresses.

A session begins with a start command. The block first reads the stored write position from the reserved page. That value becomes the read start of the new session. An erased or nonsensical value sends logging to address 0. Data bytes are then taken on a valid/ready handshake and written at rising addresses. After the last byte of the next-to-last page, the address jumps to 0, so logged data never lands in the reserved page. A stop command ends the session. The block writes the updated record back to the reserved page and pulses a done flag.

The memory side is a generic request/response port. A request carries a write-enable, an address and a write byte. Every request, read or write, is answered by one response pulse, and the block keeps at most one request outstanding.

Top module: `bytelog_wr_mgr`

## Requirements
- R1: After reset, the block issues no memory request, holds `in_ready` low and holds `done_o` low.
- R2: A start command from idle first issues three memory reads at addresses 0x1FF03, 0x1FF04 and 0x1FF05, in that order, before any write. These bytes form the stored write position, most significant byte first. `in_ready` stays low until the third read response arrives.
- R3: If the stored write position reads 0xFFFFFF (erased), or it is not an address below 0x1FF00, the session's write position and read start are both 0.
- R4: Otherwise, the first data byte of the session is written at the stored write position, and that value is also the session's read start.
- R5: Each accepted data byte produces one memory write of that byte. The address is one higher than the previous data write of the session.
- R6: The data write after address 0x1FEFF goes to address 0x00000. No data byte is ever written at 0x1FF00 or above.
- R7: At session end, nine memory writes go to 0x1FF00 through 0x1FF08 in ascending order. They carry three 24-bit fields, each most significant byte first and zero-extended: the read start (bytes 0 to 2), the new write position (bytes 3 to 5) and the byte count (bytes 6 to 8).
- R8: The stored new write position is the address after the last data write, with the skip of R6 applied. If no byte was logged, it is the session's starting position. The stored count equals the number of data bytes accepted in the session.
- R9: A stop command that arrives while a data write awaits its response is remembered. The record write-back starts only after that response, and that byte is included in the count.
- R10: `in_ready` is low while the record is read or written and in the cycle a stop is presented, so a byte offered then is not written. `done_o` is high for exactly one cycle after the response to the ninth record write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a session (accepted in idle) |
| stop_i | input | 1 | End the session and write back the record |
| in_valid | input | 1 | Data byte offered |
| in_data | input | 8 | Data byte to log |
| in_ready | output | 1 | Data byte accepted when high with `in_valid` |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 17 | Byte address |
| mem_req_wdata | output | 8 | Byte to write |
| mem_rsp_valid | input | 1 | Response to the outstanding request |
| mem_rsp_rdata | input | 8 | Read data with the response |
| done_o | output | 1 | One-cycle pulse when the record is stored |

## Verification
The bench chains sessions through a behavioural memory. Each session's stored record steers the next session. A design that ignored the record would restart at 0. One that mishandled the erased value would start at 0x1FFFF.

One session starts two bytes before the reserved page. A missing skip would put data into the record area, and the bench looks for a write at 0x1FF00.

The bench raises stop while a slow write response is pending. A design that dropped the stop would never finish, and one that acted on it too early would issue a second request while one is still outstanding.

Empty sessions and out-of-range stored pointers are also covered. A byte held on the input during write-back shows up in the log or in the count if the block takes it.

// File: rtl/bytelog_pkg.sv
package bytelog_pkg;
  localparam int unsigned FIELD_BYTES = 3;
  localparam int unsigned META_BYTES  = 3 * FIELD_BYTES;
  localparam int unsigned WPTR_OFS    = FIELD_BYTES;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MRD_REQ,
    ST_MRD_WAIT,
    ST_RUN,
    ST_DWR_WAIT,
    ST_MWR_REQ,
    ST_MWR_WAIT
  } lg_state_e;
endpackage

// File: rtl/bytelog_addr_step.sv
module bytelog_addr_step #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned PAGE_W = 8
) (
  input  logic [ADDR_W-1:0] cur_i,
  output logic [ADDR_W-1:0] nxt_o
);
  localparam logic [ADDR_W-1:0] RES_BASE  = {{(ADDR_W-PAGE_W){1'b1}}, {PAGE_W{1'b0}}};
  localparam logic [ADDR_W-1:0] LAST_DATA = RES_BASE - 1'b1;

  // Stepping past the final data byte hops over the reserved page to 0.
  always_comb begin
    if (cur_i == LAST_DATA) nxt_o = '0;
    else                    nxt_o = cur_i + 1'b1;
  end
endmodule

// File: rtl/bytelog_meta_fmt.sv
module bytelog_meta_fmt
  import bytelog_pkg::*;
#(
  parameter int unsigned ADDR_W = 17
) (
  input  logic [ADDR_W-1:0]          rd_ptr_i,
  input  logic [ADDR_W-1:0]          wr_ptr_i,
  input  logic [8*FIELD_BYTES-1:0]   cnt_i,
  input  logic [3:0]                 idx_i,
  output logic [7:0]                 byte_o
);
  localparam int unsigned FLD_W = 8 * FIELD_BYTES;
  localparam int unsigned REC_W = 8 * META_BYTES;

  logic [REC_W-1:0] rec;
  logic [7:0]       rec_bytes [META_BYTES];

  assign rec = {{(FLD_W-ADDR_W){1'b0}}, rd_ptr_i,
                {(FLD_W-ADDR_W){1'b0}}, wr_ptr_i,
                cnt_i};

  for (genvar g = 0; g < META_BYTES; g++) begin : g_slice
    assign rec_bytes[g] = rec[REC_W-1-8*g -: 8];
  end

  always_comb begin
    byte_o = '0;
    for (int k = 0; k < META_BYTES; k++) begin
      if (idx_i == 4'(k)) byte_o = rec_bytes[k];
    end
  end
endmodule

// File: rtl/bytelog_wr_mgr.sv
module bytelog_wr_mgr
  import bytelog_pkg::*;
#(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [7:0]        mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [7:0]        mem_rsp_rdata,
  output logic              done_o
);
  localparam int unsigned FLD_W = 8 * FIELD_BYTES;
  localparam logic [ADDR_W-1:0] RES_BASE = {{(ADDR_W-PAGE_W){1'b1}}, {PAGE_W{1'b0}}};
  localparam logic [3:0] RD_LAST   = 4'(FIELD_BYTES - 1);
  localparam logic [3:0] META_LAST = 4'(META_BYTES - 1);

  lg_state_e         state_q, state_n;
  logic [3:0]        idx_q, idx_n;
  logic [FLD_W-9:0]  sw_q, sw_n;
  logic [ADDR_W-1:0] rd_ptr_q, rd_ptr_n;
  logic [ADDR_W-1:0] wr_ptr_q, wr_ptr_n;
  logic [FLD_W-1:0]  cnt_q, cnt_n;
  logic              pend_q, pend_n;
  logic              done_q, done_n;

  logic [ADDR_W-1:0] wr_ptr_step;
  logic [7:0]        meta_byte;
  logic [FLD_W-1:0]  stored_wp;
  logic              stored_bad;
  logic              req_fire;

  bytelog_addr_step #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_step (
    .cur_i (wr_ptr_q),
    .nxt_o (wr_ptr_step)
  );

  bytelog_meta_fmt #(.ADDR_W(ADDR_W)) u_fmt (
    .rd_ptr_i (rd_ptr_q),
    .wr_ptr_i (wr_ptr_q),
    .cnt_i    (cnt_q),
    .idx_i    (idx_q),
    .byte_o   (meta_byte)
  );

  // Stored write position assembled from the two earlier bytes and this response.
  assign stored_wp  = {sw_q, mem_rsp_rdata};
  assign stored_bad = (stored_wp == {FLD_W{1'b1}}) ||
                      (stored_wp[FLD_W-1:ADDR_W] != '0) ||
                      (stored_wp[ADDR_W-1:0] >= RES_BASE);

  // Request port and input handshake.
  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_we    = 1'b0;
    mem_req_addr  = '0;
    mem_req_wdata = '0;
    in_ready      = 1'b0;
    unique case (state_q)
      ST_MRD_REQ: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = RES_BASE + ADDR_W'(WPTR_OFS) + ADDR_W'(idx_q);
      end
      ST_RUN: begin
        mem_req_valid = in_valid && !stop_i;
        mem_req_we    = 1'b1;
        mem_req_addr  = wr_ptr_q;
        mem_req_wdata = in_data;
        in_ready      = mem_req_ready && !stop_i;
      end
      ST_MWR_REQ: begin
        mem_req_valid = 1'b1;
        mem_req_we    = 1'b1;
        mem_req_addr  = RES_BASE + ADDR_W'(idx_q);
        mem_req_wdata = meta_byte;
      end
      default: ;
    endcase
  end

  assign req_fire = mem_req_valid && mem_req_ready;

  // Next-state logic.
  always_comb begin
    state_n  = state_q;
    idx_n    = idx_q;
    sw_n     = sw_q;
    rd_ptr_n = rd_ptr_q;
    wr_ptr_n = wr_ptr_q;
    cnt_n    = cnt_q;
    pend_n   = pend_q;
    done_n   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_n = ST_MRD_REQ;
          idx_n   = '0;
        end
      end
      ST_MRD_REQ: begin
        if (req_fire) state_n = ST_MRD_WAIT;
      end
      ST_MRD_WAIT: begin
        if (mem_rsp_valid) begin
          sw_n = {sw_q[FLD_W-17:0], mem_rsp_rdata};
          if (idx_q == RD_LAST) begin
            rd_ptr_n = stored_bad ? '0 : stored_wp[ADDR_W-1:0];
            wr_ptr_n = stored_bad ? '0 : stored_wp[ADDR_W-1:0];
            cnt_n    = '0;
            pend_n   = 1'b0;
            state_n  = ST_RUN;
          end else begin
            idx_n   = idx_q + 1'b1;
            state_n = ST_MRD_REQ;
          end
        end
      end
      ST_RUN: begin
        if (stop_i) begin
          idx_n   = '0;
          state_n = ST_MWR_REQ;
        end else if (req_fire) begin
          wr_ptr_n = wr_ptr_step;
          cnt_n    = cnt_q + 1'b1;
          state_n  = ST_DWR_WAIT;
        end
      end
      ST_DWR_WAIT: begin
        if (stop_i) pend_n = 1'b1;
        if (mem_rsp_valid) begin
          if (pend_q || stop_i) begin
            pend_n  = 1'b0;
            idx_n   = '0;
            state_n = ST_MWR_REQ;
          end else begin
            state_n = ST_RUN;
          end
        end
      end
      ST_MWR_REQ: begin
        if (req_fire) state_n = ST_MWR_WAIT;
      end
      ST_MWR_WAIT: begin
        if (mem_rsp_valid) begin
          if (idx_q == META_LAST) begin
            done_n  = 1'b1;
            state_n = ST_IDLE;
          end else begin
            idx_n   = idx_q + 1'b1;
            state_n = ST_MWR_REQ;
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  // State registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      sw_q     <= '0;
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
      pend_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_n;
      idx_q    <= idx_n;
      sw_q     <= sw_n;
      rd_ptr_q <= rd_ptr_n;
      wr_ptr_q <= wr_ptr_n;
      cnt_q    <= cnt_n;
      pend_q   <= pend_n;
      done_q   <= done_n;
    end
  end

  assign done_o = done_q;

  // Data writes never target the reserved page.
  assert_no_reserved_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_we && state_q == ST_RUN) |-> (mem_req_addr < RES_BASE));

  // Record writes stay inside the reserved page.
  assert_meta_in_page_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_we && state_q == ST_MWR_REQ) |-> (mem_req_addr >= RES_BASE));

  // One request at a time: an accepted request is followed by a quiet port.
  assert_one_outstanding_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> !mem_req_valid);

  // No input accepted outside the logging phase.
  assert_ready_only_logging_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_RUN) |-> !in_ready);

  // Done is a single-cycle pulse.
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // Write position always stays in the data area.
  assert_wptr_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |-> (wr_ptr_q < RES_BASE));
endmodule

// File: tb/bytelog_wr_mgr_test.sv
module bytelog_wr_mgr_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        stop_i = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_ready;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic        mem_req_we;
  logic [16:0] mem_req_addr;
  logic [7:0]  mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [7:0]  mem_rsp_rdata = 8'h00;
  logic        done_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int lat = 1;
  bit bp = 1'b0;

  logic [7:0]  mem [int];
  logic [16:0] log_addr [$];
  logic [7:0]  log_data [$];
  logic        log_we   [$];
  logic [7:0]  sent     [$];

  bytelog_wr_mgr uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata), .done_o(done_o)
  );

  always #10 clk = ~clk;

  // Behavioural memory: one response per request after lat cycles.
  int   rcnt = 0;
  bit   busy = 1'b0;
  logic [7:0] rhold = 8'h00;
  always @(posedge clk) begin
    cycles <= cycles + 1;
    mem_rsp_valid <= 1'b0;
    mem_req_ready <= bp ? ~mem_req_ready : 1'b1;
    if (busy) begin
      if (rcnt == 0) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_rdata <= rhold;
        busy = 1'b0;
      end else begin
        rcnt = rcnt - 1;
      end
    end
    if (rst_n && mem_req_valid && mem_req_ready) begin
      log_addr.push_back(mem_req_addr);
      log_data.push_back(mem_req_wdata);
      log_we.push_back(mem_req_we);
      if (mem_req_we) mem[int'(mem_req_addr)] = mem_req_wdata;
      rhold = mem.exists(int'(mem_req_addr)) ? mem[int'(mem_req_addr)] : 8'hFF;
      busy  = 1'b1;
      rcnt  = lat - 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [16:0] step(input logic [16:0] a);
    return (a == 17'h1FEFF) ? 17'h0 : a + 17'h1;
  endfunction

  task automatic set_wp(input logic [23:0] v);
    mem[32'h1FF03] = v[23:16];
    mem[32'h1FF04] = v[15:8];
    mem[32'h1FF05] = v[7:0];
  endtask

  task automatic pulse_start();
    log_addr.delete(); log_data.delete(); log_we.delete(); sent.delete();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    int guard = 0;
    in_valid = 1'b1; in_data = b;
    #1;
    while (!in_ready && guard < 500) begin
      @(negedge clk); #1; guard++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    sent.push_back(b);
  endtask

  // Stop with a byte held on the input; that byte must not be taken (R10).
  task automatic stop_and_wait();
    int guard = 0;
    bit seen = 1'b0;
    stop_i = 1'b1; in_valid = 1'b1; in_data = 8'hEE;
    @(negedge clk); stop_i = 1'b0;
    while (!seen && guard < 3000) begin
      if (done_o) seen = 1'b1;
      else begin @(negedge clk); guard++; end
    end
    in_valid = 1'b0;
    chk(seen, "R10 done reached", int'(seen), 1);
    @(negedge clk);
    chk(!done_o, "R10 done single cycle", int'(done_o), 0);
  endtask

  task automatic verify(input logic [16:0] first, input logic [16:0] rd_exp);
    int n = sent.size();
    logic [16:0] a = first;
    logic [23:0] fld [3];
    chk(log_addr.size() == 3 + n + 9, "R8 request count", log_addr.size(), 3 + n + 9);
    if (log_addr.size() != 3 + n + 9) return;
    for (int i = 0; i < 3; i++)
      chk(!log_we[i] && log_addr[i] == 17'h1FF03 + 17'(i), "R2 record read",
          int'(log_addr[i]), 32'h1FF03 + i);
    for (int i = 0; i < n; i++) begin
      chk(log_we[3+i] && log_addr[3+i] == a && log_data[3+i] == sent[i],
          "R5 data write", int'(log_addr[3+i]), int'(a));
      chk(log_addr[3+i] < 17'h1FF00, "R6 data outside reserved page", int'(log_addr[3+i]), 0);
      a = step(a);
    end
    fld[0] = {7'h0, rd_exp}; fld[1] = {7'h0, a}; fld[2] = 24'(n);
    for (int i = 0; i < 9; i++) begin
      logic [7:0] e = fld[i/3][23 - 8*(i%3) -: 8];
      chk(log_we[3+n+i] && log_addr[3+n+i] == 17'h1FF00 + 17'(i) && log_data[3+n+i] == e,
          "R7 R8 record byte", int'(log_data[3+n+i]), int'(e));
    end
  endtask

  task automatic t_reset();
    chk(!mem_req_valid, "R1 no request", int'(mem_req_valid), 0);
    chk(!in_ready, "R1 ready low", int'(in_ready), 0);
    chk(!done_o, "R1 done low", int'(done_o), 0);
  endtask

  task automatic t_first_use();
    lat = 1; bp = 1'b0;
    pulse_start();
    chk(!in_ready, "R2 ready low while reading", int'(in_ready), 0);
    send(8'hA1); send(8'hA2); send(8'hA3);
    stop_and_wait();
    verify(17'h0, 17'h0);  // R3 erased record starts at 0
  endtask

  task automatic t_resume();
    lat = 2; bp = 1'b1;
    pulse_start();
    send(8'h51); send(8'h52);
    stop_and_wait();
    verify(17'h3, 17'h3);  // R4 continues from stored position
    bp = 1'b0;
  endtask

  task automatic t_wrap();
    lat = 1;
    set_wp(24'h01FEFE);
    pulse_start();
    send(8'h10); send(8'h11); send(8'h12);
    stop_and_wait();
    verify(17'h1FEFE, 17'h1FEFE);  // R6 hop from 0x1FEFF to 0
    chk(!mem.exists(32'h1FF09), "R6 reserved page untouched", 0, 0);
  endtask

  task automatic t_stop_pending();
    lat = 6;
    pulse_start();
    send(8'h77);
    stop_and_wait();  // stop lands while the data response is pending (R9)
    verify(17'h1, 17'h1);
    lat = 1;
  endtask

  task automatic t_empty();
    pulse_start();
    repeat (12) @(negedge clk);
    stop_and_wait();
    verify(17'h2, 17'h2);  // R8 zero count, position unchanged
  endtask

  task automatic t_bad_pointer();
    set_wp(24'h01FF10);
    pulse_start();
    send(8'h3C);
    stop_and_wait();
    verify(17'h0, 17'h0);  // R3 out-of-range record starts at 0
  endtask

  always @(posedge clk) begin
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_first_use();
    t_resume();
    t_wrap();
    t_stop_pending();
    t_empty();
    t_bad_pointer();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule